// File: doc/BRIEF.md
# Grouped Interrupt Flag and Mask Multiplexer

This block collects up to fourteen external interrupt inputs and presents them to a processor as four interrupt lines. Each input passes through a two-stage synchronizer. A rising edge on the synchronized input sets a sticky bit in a 16-bit flag register. A 16-bit mask register, in which a 1 blocks a source, gates the flags. Every output line is the registered OR of the flagged, unmasked sources in its own fixed group. The groups are scattered, non-contiguous sets of bits.

Software reaches both registers over a plain 16-bit register bus, which has a byte address, a write strobe, write data, a read strobe and registered read data. A typical service routine runs in four steps. It reads the mask, masks the sources it is about to handle, clears their flags by writing the complement of their bit set, and then writes the saved mask back. For this to work, a mask read must return exactly what was last written.

Top module: `irq_group_mux`

## Requirements
- R1: After reset the mask register reads 0x7FFE, the flag register reads 0x0000, all four interrupt lines are low and the read data is 0x0000.
- R2: The mask register sits at byte offset 0x04. Reading it returns exactly the 16-bit value last written there, including bits 0 and 15.
- R3: A mask bit of 1 stops its flagged source from driving any line. A mask bit of 0 lets it through.
- R4: A write to the flag register at byte offset 0x0C clears each flag whose written bit is 0 and leaves alone each flag whose written bit is 1.
- R5: A flag sets on a rising edge of its input and is set at the third rising clock edge after the input is first sampled high. It stays set until software clears it. An input held high does not set the flag again after a clear.
- R6: Flag bits 0 and 15 always read 0, and inputs 0 and 15 never drive a line.
- R7: Line 0 serves sources {3,5}. Line 1 serves {4,6}. Line 2 serves {10,11,12}. Line 3 serves {1,2,7,8,9,13,14}. These are group masks 0x0028, 0x0050, 0x1C00 and 0x6386.
- R8: When a source edge and a software clear of the same flag land in the same cycle, the flag stays set.
- R9: Each line is registered. It rises or falls one clock after the flag or mask change that causes it, which puts it one clock after the register write edge.
- R10: Read data appears one clock after the read strobe. Reads of any offset other than 0x04 and 0x0C return 0, and writes to such offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| src_in | input | 16 | Asynchronous interrupt inputs; bits 0 and 15 unused |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| irq_line | output | 4 | Group interrupt lines to the processor |

## Verification
Two functions can act on one flag bit in the same clock: a synchronized source edge setting it, and a software write to the flag register clearing it. The bench first latches a source and lets it settle. It then raises that source again and times a clear-all write so that the write edge coincides with the edge detector's active cycle. The judgement comes from a register read-back. The colliding bit must still read as 1, and a second flag cleared by the same write must read as 0, which shows that the clear itself took effect.

// File: rtl/irq_group_mux_pkg.sv
package irq_group_mux_pkg;

  localparam int REG_W     = 16;
  localparam int NUM_LINES = 4;

  // sources that exist; bits 0 and 15 are never wired
  localparam logic [REG_W-1:0] USED_SRC = 16'h7FFE;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_FLAG = 2'd2
  } reg_sel_e;

  // fixed group membership of each output line
  function automatic logic [REG_W-1:0] group_of(input int line);
    case (line)
      0:       group_of = 16'h0028;
      1:       group_of = 16'h0050;
      2:       group_of = 16'h1C00;
      3:       group_of = 16'h6386;
      default: group_of = '0;
    endcase
  endfunction

  // next flag state: keep bits not cleared, new events always win
  function automatic logic [REG_W-1:0] flag_next(input logic [REG_W-1:0] cur,
                                                 input logic [REG_W-1:0] keep,
                                                 input logic [REG_W-1:0] ev);
    flag_next = ((cur & keep) | ev) & USED_SRC;
  endfunction

  // a line is pending when any group member is flagged and not masked
  function automatic logic line_pending(input logic [REG_W-1:0] flag,
                                        input logic [REG_W-1:0] mask,
                                        input logic [REG_W-1:0] grp);
    line_pending = |(flag & ~mask & grp);
  endfunction

endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  output logic rise
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-1:0], src};
  end

  assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import irq_group_mux_pkg::*;
#(
  parameter int               ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] MASK_OFS  = 'h04,
  parameter logic [ADDR_W-1:0] FLAG_OFS  = 'h0C,
  parameter logic [REG_W-1:0] RESET_MASK = 16'h7FFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [REG_W-1:0]  wdata,
  input  logic              re,
  output logic [REG_W-1:0]  rdata,
  input  logic [REG_W-1:0]  edge_ev,
  output logic [REG_W-1:0]  mask_q,
  output logic [REG_W-1:0]  flag_q,
  output logic              mask_wr,
  output logic              flag_wr
);
  reg_sel_e         sel;
  logic [REG_W-1:0] keep_vec;
  logic [REG_W-1:0] rd_mux;

  always_comb begin
    if (addr == MASK_OFS)      sel = SEL_MASK;
    else if (addr == FLAG_OFS) sel = SEL_FLAG;
    else                       sel = SEL_NONE;
  end

  assign mask_wr  = we && (sel == SEL_MASK);
  assign flag_wr  = we && (sel == SEL_FLAG);
  assign keep_vec = flag_wr ? wdata : '1;

  always_comb begin
    case (sel)
      SEL_MASK: rd_mux = mask_q;
      SEL_FLAG: rd_mux = flag_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= RESET_MASK;
      flag_q <= '0;
      rdata  <= '0;
    end else begin
      if (mask_wr) mask_q <= wdata;
      flag_q <= flag_next(flag_q, keep_vec, edge_ev);
      rdata  <= re ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/irq_line_combine.sv
module irq_line_combine
  import irq_group_mux_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [REG_W-1:0]     flag,
  input  logic [REG_W-1:0]     mask,
  output logic [NUM_LINES-1:0] line_q
);
  logic [NUM_LINES-1:0] line_d;

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    assign line_d[k] = line_pending(flag, mask, group_of(k));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end
endmodule

// File: rtl/irq_group_mux.sv
module irq_group_mux
  import irq_group_mux_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] MASK_OFS    = 'h04,
  parameter logic [ADDR_W-1:0] FLAG_OFS    = 'h0C,
  parameter int                SYNC_STAGES = 2,
  parameter logic [15:0]       RESET_MASK  = 16'h7FFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       src_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [15:0]       bus_wdata,
  input  logic              bus_re,
  output logic [15:0]       bus_rdata,
  output logic [3:0]        irq_line
);
  // named internal events, visible to the bound checker
  logic [REG_W-1:0] edge_ev;
  logic [REG_W-1:0] mask_q;
  logic [REG_W-1:0] flag_q;
  logic             mask_wr;
  logic             flag_wr;

  for (genvar b = 0; b < REG_W; b++) begin : g_src
    if (USED_SRC[b]) begin : g_used
      irq_src_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .src  (src_in[b]),
        .rise (edge_ev[b])
      );
    end else begin : g_unused
      assign edge_ev[b] = 1'b0;
    end
  end

  irq_reg_file #(
    .ADDR_W    (ADDR_W),
    .MASK_OFS  (MASK_OFS),
    .FLAG_OFS  (FLAG_OFS),
    .RESET_MASK(RESET_MASK)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (bus_addr),
    .we     (bus_we),
    .wdata  (bus_wdata),
    .re     (bus_re),
    .rdata  (bus_rdata),
    .edge_ev(edge_ev),
    .mask_q (mask_q),
    .flag_q (flag_q),
    .mask_wr(mask_wr),
    .flag_wr(flag_wr)
  );

  irq_line_combine u_lines (
    .clk   (clk),
    .rst_n (rst_n),
    .flag  (flag_q),
    .mask  (mask_q),
    .line_q(irq_line)
  );
endmodule

// File: rtl/irq_group_mux_chk.sv
module irq_group_mux_chk
  import irq_group_mux_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'h04,
  parameter logic [ADDR_W-1:0] FLAG_OFS = 'h0C
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [15:0]       bus_wdata,
  input logic              bus_re,
  input logic [15:0]       bus_rdata,
  input logic [3:0]        irq_line,
  input logic [15:0]       mask_q,
  input logic [15:0]       flag_q,
  input logic [15:0]       edge_ev
);
  logic [3:0] pend_now;
  always_comb begin
    for (int k = 0; k < 4; k++)
      pend_now[k] = |(flag_q & ~mask_q & group_of(k));
  end

  logic other_addr;
  assign other_addr = (bus_addr != MASK_OFS) && (bus_addr != FLAG_OFS);

  a_r2_mask_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == MASK_OFS) |=> (mask_q == $past(bus_wdata)));

  a_r10_mask_read_lat: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == MASK_OFS) |=> (bus_rdata == $past(mask_q)));

  a_r10_other_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && other_addr) |=> (bus_rdata == 16'h0000));

  a_r10_other_writes_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && other_addr) |=> $stable(mask_q));

  a_r6_unused_flags_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[0] == 1'b0 && flag_q[15] == 1'b0));

  a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_ev) |=> ((flag_q & $past(edge_ev)) == $past(edge_ev)));

  a_r4_zero_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == FLAG_OFS) |=>
      ((flag_q & ~$past(bus_wdata) & ~$past(edge_ev)) == 16'h0000));

  a_r9_line_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_line == $past(pend_now)));

  a_r3_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q & USED_SRC) == USED_SRC) |=> (irq_line == 4'h0));
endmodule

bind irq_group_mux irq_group_mux_chk #(
  .ADDR_W  (ADDR_W),
  .MASK_OFS(MASK_OFS),
  .FLAG_OFS(FLAG_OFS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_we   (bus_we),
  .bus_wdata(bus_wdata),
  .bus_re   (bus_re),
  .bus_rdata(bus_rdata),
  .irq_line (irq_line),
  .mask_q   (mask_q),
  .flag_q   (flag_q),
  .edge_ev  (edge_ev)
);

// File: tb/sim_irq_group_mux.sv
module sim_irq_group_mux;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_MASK = 8'h04;
  localparam logic [7:0] A_FLAG = 8'h0C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_in = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [15:0] bus_rdata;
  logic [3:0]  irq_line;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  irq_group_mux u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .irq_line(irq_line)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // line expected for a single source, written as membership lists
  function automatic logic [3:0] line_for(input int b);
    case (b)
      3, 5:                    line_for = 4'b0001;
      4, 6:                    line_for = 4'b0010;
      10, 11, 12:              line_for = 4'b0100;
      1, 2, 7, 8, 9, 13, 14:   line_for = 4'b1000;
      default:                 line_for = 4'b0000;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  // pulse one source; on return its flag and line have settled
  task automatic fire(input int b);
    src_in[b] = 1'b1;
    repeat (4) @(negedge clk);
    src_in[b] = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 rdata", bus_rdata, 16'h0000);
    check("R1 lines", {12'h0, irq_line}, 16'h0000);
    rd(A_MASK, d); check("R1 mask", d, 16'h7FFE);
    rd(A_FLAG, d); check("R1 flag", d, 16'h0000);
  endtask

  task automatic t_mask_rw();
    logic [15:0] d;
    wr(A_MASK, 16'hA5C3); rd(A_MASK, d); check("R2 readback a5c3", d, 16'hA5C3);
    wr(A_MASK, 16'hFFFF); rd(A_MASK, d); check("R2 readback ffff", d, 16'hFFFF);
    wr(A_MASK, 16'h0000); rd(A_MASK, d); check("R2 readback 0000", d, 16'h0000);
  endtask

  task automatic t_groups();
    logic [15:0] d;
    wr(A_MASK, 16'h0000);
    for (int b = 1; b <= 14; b++) begin
      fire(b);
      check($sformatf("R7 line for src %0d", b), {12'h0, irq_line}, {12'h0, line_for(b)});
      rd(A_FLAG, d);
      check($sformatf("R5 flag for src %0d", b), d, 16'(1) << b);
      wr(A_FLAG, 16'h0000);
      @(negedge clk);
      check("R4 clear-all drops line", {12'h0, irq_line}, 16'h0000);
    end
  endtask

  task automatic t_unused();
    logic [15:0] d;
    fire(0); fire(15);
    check("R6 unused lines", {12'h0, irq_line}, 16'h0000);
    rd(A_FLAG, d); check("R6 unused flags", d, 16'h0000);
  endtask

  task automatic t_masking();
    logic [15:0] d;
    wr(A_MASK, 16'h7FFE);
    fire(3);
    rd(A_FLAG, d); check("R3 masked flag still latched", d, 16'h0008);
    check("R3 masked source silent", {12'h0, irq_line}, 16'h0000);
    wr(A_MASK, 16'h7FF6);
    check("R9 line not yet up", {12'h0, irq_line}, 16'h0000);
    @(negedge clk);
    check("R9 line up one cycle later", {12'h0, irq_line}, 16'h0001);
    wr(A_MASK, 16'h7FFE);
    check("R9 line still up", {12'h0, irq_line}, 16'h0001);
    @(negedge clk);
    check("R3 R9 line down after mask", {12'h0, irq_line}, 16'h0000);
  endtask

  task automatic t_partial_clear();
    logic [15:0] d;
    fire(10);
    rd(A_FLAG, d); check("R4 both flags", d, 16'h0408);
    wr(A_FLAG, 16'hFFF7);
    rd(A_FLAG, d); check("R4 partial clear", d, 16'h0400);
    wr(A_FLAG, 16'h0000);
    rd(A_FLAG, d); check("R4 full clear", d, 16'h0000);
  endtask

  task automatic t_level_held();
    logic [15:0] d;
    src_in[5] = 1'b1;
    repeat (6) @(negedge clk);
    rd(A_FLAG, d); check("R5 held level sets", d, 16'h0020);
    wr(A_FLAG, 16'h0000);
    repeat (4) @(negedge clk);
    rd(A_FLAG, d); check("R5 no re-set while held", d, 16'h0000);
    src_in[5] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_collision();
    logic [15:0] d;
    fire(4); fire(6);
    rd(A_FLAG, d); check("R8 setup", d, 16'h0050);
    src_in[4] = 1'b1;
    repeat (2) @(negedge clk);
    wr(A_FLAG, 16'h0000);
    src_in[4] = 1'b0;
    rd(A_FLAG, d); check("R8 edge wins over clear", d, 16'h0010);
    wr(A_FLAG, 16'h0000);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_other_offset();
    logic [15:0] d;
    wr(A_MASK, 16'h1234);
    fire(11);
    wr(8'h08, 16'hFFFF);
    wr(8'h00, 16'h0000);
    rd(A_MASK, d); check("R10 stray writes ignored (mask)", d, 16'h1234);
    rd(A_FLAG, d); check("R10 stray writes ignored (flag)", d, 16'h0800);
    rd(8'h08, d);  check("R10 offset 08 reads zero", d, 16'h0000);
    rd(8'h0E, d);  check("R10 offset 0e reads zero", d, 16'h0000);
    bus_addr = A_MASK; bus_re = 1'b1;
    #1;
    check("R10 no data before edge", bus_rdata, 16'h0000);
    @(negedge clk); bus_re = 1'b0;
    check("R10 data one cycle after strobe", bus_rdata, 16'h1234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask_rw();
    t_groups();
    t_unused();
    t_masking();
    t_partial_clear();
    t_level_held();
    t_collision();
    t_other_offset();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule